// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a multithreaded out-of-order core, each commit slot retires from one hardware thread. This block decides which thread that is. For every thread it receives a commit status code, a flag that the reorder buffer holds at least one entry, a flag that the oldest entry may retire, and that entry's sequence number. A static two-bit policy select chooses one of three selection rules. One rule picks greedily. One rotates the threads fairly. One picks the thread holding the oldest ready instruction.

Each clock cycle the block answers up to `NUM_SLOTS` slot requests. Every answer is combinational and consists of a valid flag and a thread index. The round-robin order is held inside the block. When the rotating policy is active, a pick made for one slot reorders the list before the next slot in the same cycle is resolved. The reordered list is registered at the clock edge and carries into the following cycle.

Top module: `commit_thread_sel`

## Requirements
- R1: A thread can be selected only when its 3-bit status code is 0 (idle), 1 (running) or 4 (waiting on a fetch-side trap). Codes 2 (buffer squashing), 3 (trap pending) and 5 to 7 exclude the thread.
- R2: With more than one thread configured, a thread is a candidate only when its buffer-not-empty flag and its head-ready flag are both 1.
- R3: With policy 2 (oldest-ready), a requested slot gets the candidate with the smallest head sequence number. Sequence numbers are compared as 32-bit unsigned values.
- R4: When two or more candidates share the smallest sequence number, the lowest thread index wins.
- R5: Policy 0 (greedy) uses the same rule as oldest-ready. Every requested slot in the cycle receives that same thread.
- R6: With policy 1 (rotating), a requested slot gets the first candidate found from the front of the priority list. That thread is then moved to the back of the list. A later slot in the same cycle sees the reordered list, and the list persists into the next cycle.
- R7: Reset loads the priority list with the thread indices in ascending order, with thread 0 at the front.
- R8: A slot reports no selection when policy 3 is selected, when no thread is a candidate, or when the slot is not requested.
- R9: With a single thread configured, a requested slot returns thread 0 whenever its status is eligible. The buffer and readiness flags are ignored in this case. Policy 3 still gives no selection.
- R10: The priority list does not change in a cycle in which the rotating policy makes no pick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| policySel | input | 2 | 0 greedy, 1 rotating, 2 oldest-ready, 3 none |
| threadStatus | input | NUM_THREADS*3 | Per-thread commit status code, thread t at bits [3t+2:3t] |
| robNotEmpty | input | NUM_THREADS | Per-thread reorder buffer holds an entry |
| headReady | input | NUM_THREADS | Per-thread oldest entry may retire |
| headSeq | input | NUM_THREADS*SEQ_W | Per-thread head sequence number, thread t at [SEQ_W*t +: SEQ_W] |
| slotReq | input | NUM_SLOTS | Slot k asks for a thread this cycle |
| slotValid | output | NUM_SLOTS | Slot k received a thread |
| slotThread | output | NUM_SLOTS*TW | Thread index for slot k at [TW*k +: TW] |

## Verification
Two selections can resolve in the same cycle. Under the rotating policy, the pick for slot 0 reorders the list, and that reordered list decides slot 1. Under the oldest-ready policy, the same cycle can also change status codes that remove the oldest thread. The bench requests both slots at once, both in directed sequences starting from the reset order and under seeded random traffic. It compares both answers against a bench model that applies the rotation twice per cycle. The single-thread instance runs alongside on the same policy select, to confirm that readiness is ignored.

// File: rtl/cts_pkg.sv
package cts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE            = 3'd0,
    ST_RUNNING         = 3'd1,
    ST_ROB_SQUASH      = 3'd2,
    ST_TRAP_WAIT       = 3'd3,
    ST_FETCH_TRAP_WAIT = 3'd4
  } thrStatus_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_NONE   = 2'd3
  } policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cmpEn;      // run the oldest-sequence comparison
    logic gateReady;  // require buffer-not-empty and head-ready
  } dpCtl_t;

  function automatic logic statusOk(input logic [2:0] code);
    return (code == ST_IDLE) || (code == ST_RUNNING) || (code == ST_FETCH_TRAP_WAIT);
  endfunction

endpackage

// File: rtl/cts_datapath.sv
module cts_datapath
  import cts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 32,
  parameter int TW          = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtl_t                       dpCtl,
  input  logic [NUM_THREADS*3-1:0]     threadStatus,
  input  logic [NUM_THREADS-1:0]       robNotEmpty,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  output logic [NUM_THREADS-1:0]       candMask,
  output logic                         oldValid,
  output logic [TW-1:0]                oldIdx
);

  // per-thread candidate qualification
  for (genvar t = 0; t < NUM_THREADS; t++) begin : gQual
    logic statOk;
    assign statOk = statusOk(threadStatus[t*3 +: 3]);
    assign candMask[t] = statOk && (!dpCtl.gateReady || (robNotEmpty[t] && headReady[t]));
  end

  // oldest head scan, strict compare keeps the lower index on ties
  always_comb begin : oldestScan
    logic             found;
    logic [TW-1:0]    bestIdx;
    logic [SEQ_W-1:0] bestSeq;
    found   = 1'b0;
    bestIdx = '0;
    bestSeq = '0;
    if (dpCtl.cmpEn) begin
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (candMask[i] && (!found || (headSeq[i*SEQ_W +: SEQ_W] < bestSeq))) begin
          found   = 1'b1;
          bestIdx = TW'(i);
          bestSeq = headSeq[i*SEQ_W +: SEQ_W];
        end
      end
    end
    oldValid = found;
    oldIdx   = bestIdx;
  end

  for (genvar j = 0; j < NUM_THREADS; j++) begin : gOldChk
    AST_OLDEST_MIN: assert property (@(posedge clk) disable iff (!rstN)
      (oldValid && candMask[j]) |-> (headSeq[oldIdx*SEQ_W +: SEQ_W] <= headSeq[j*SEQ_W +: SEQ_W])) else $error("oldest pick not minimal"); // R3
    AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (!rstN)
      (oldValid && candMask[j] && (j < int'(oldIdx))) |-> (headSeq[oldIdx*SEQ_W +: SEQ_W] < headSeq[j*SEQ_W +: SEQ_W])) else $error("tie not resolved to low index"); // R4
  end

endmodule

// File: rtl/cts_ctrl.sv
module cts_ctrl
  import cts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 2,
  parameter int TW          = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                policySel,
  input  logic [NUM_THREADS-1:0]    candMask,
  input  logic                      oldValid,
  input  logic [TW-1:0]             oldIdx,
  input  logic [NUM_SLOTS-1:0]      slotReq,
  output dpCtl_t                    dpCtl,
  output logic [NUM_SLOTS-1:0]      slotValid,
  output logic [NUM_SLOTS*TW-1:0]   slotThread
);

  localparam logic GATE_READY = (NUM_THREADS > 1);

  policy_e pol;
  assign pol = policy_e'(policySel);

  always_comb begin
    dpCtl.cmpEn     = (pol == POL_GREEDY) || (pol == POL_OLDEST);
    dpCtl.gateReady = GATE_READY;
  end

  logic [TW-1:0] rrList [NUM_THREADS];
  logic [TW-1:0] rrNext [NUM_THREADS];
  logic          rrAdvance;

  // slot chain: each requested slot sees the list left by the one before
  always_comb begin : slotChain
    logic [TW-1:0] cur [NUM_THREADS];
    logic [TW-1:0] nxt [NUM_THREADS];
    logic          hit;
    int            pos;
    cur        = rrList;
    rrAdvance  = 1'b0;
    slotValid  = '0;
    slotThread = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      nxt = cur;
      hit = 1'b0;
      pos = 0;
      if (slotReq[k]) begin
        if (dpCtl.cmpEn) begin
          slotValid[k]             = oldValid;
          slotThread[k*TW +: TW]   = oldIdx;
        end else if (pol == POL_ROTATE) begin
          for (int p = 0; p < NUM_THREADS; p++) begin
            if (!hit && candMask[cur[p]]) begin
              hit = 1'b1;
              pos = p;
            end
          end
          if (hit) begin
            slotValid[k]           = 1'b1;
            slotThread[k*TW +: TW] = cur[pos];
            rrAdvance              = 1'b1;
            for (int i = 0; i < NUM_THREADS; i++) begin
              if (i < pos)                  nxt[i] = cur[i];
              else if (i < NUM_THREADS - 1) nxt[i] = cur[(i + 1) % NUM_THREADS];
              else                          nxt[i] = cur[pos];
            end
          end
        end
      end
      cur = nxt;
    end
    rrNext = cur;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_THREADS; i++) rrList[i] <= TW'(i);
    end else if (rrAdvance) begin
      rrList <= rrNext;
    end
  end

  // flattened view of the list for checking
  logic [NUM_THREADS*TW-1:0] rrFlat;
  for (genvar i = 0; i < NUM_THREADS; i++) begin : gFlat
    assign rrFlat[i*TW +: TW] = rrList[i];
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : gPerm
    logic [NUM_THREADS-1:0] seen;
    for (genvar i = 0; i < NUM_THREADS; i++) begin : gSeen
      assign seen[i] = (rrList[i] == TW'(t));
    end
    AST_RR_PERMUTATION: assert property (@(posedge clk) disable iff (!rstN)
      $countones(seen) == 1) else $error("priority list lost a thread"); // R6
  end

  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rrAdvance |=> $stable(rrFlat)) else $error("list moved without a pick"); // R10
  AST_POLICY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pol == POL_NONE) |-> (slotValid == '0)) else $error("selection under policy 3"); // R8
  AST_UNASKED_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid & ~slotReq) == '0) else $error("unrequested slot valid"); // R8

endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import cts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 32,
  parameter int NUM_SLOTS   = 2,
  localparam int TW         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   policySel,
  input  logic [NUM_THREADS*3-1:0]     threadStatus,
  input  logic [NUM_THREADS-1:0]       robNotEmpty,
  input  logic [NUM_THREADS-1:0]       headReady,
  input  logic [NUM_THREADS*SEQ_W-1:0] headSeq,
  input  logic [NUM_SLOTS-1:0]         slotReq,
  output logic [NUM_SLOTS-1:0]         slotValid,
  output logic [NUM_SLOTS*TW-1:0]      slotThread
);

  dpCtl_t                 dpCtl;
  logic [NUM_THREADS-1:0] candMask;
  logic                   oldValid;
  logic [TW-1:0]          oldIdx;

  cts_datapath #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TW(TW)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .threadStatus(threadStatus), .robNotEmpty(robNotEmpty),
    .headReady(headReady), .headSeq(headSeq),
    .candMask(candMask), .oldValid(oldValid), .oldIdx(oldIdx)
  );

  cts_ctrl #(.NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS), .TW(TW)) uCtrl (
    .clk(clk), .rstN(rstN), .policySel(policySel),
    .candMask(candMask), .oldValid(oldValid), .oldIdx(oldIdx),
    .slotReq(slotReq), .dpCtl(dpCtl),
    .slotValid(slotValid), .slotThread(slotThread)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : gSlotChk
    AST_SEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
      slotValid[k] |-> statusOk(threadStatus[slotThread[k*TW +: TW]*3 +: 3])) else $error("ineligible thread selected"); // R1
  end

endmodule

// File: tb/commit_thread_sel_test.sv
module commit_thread_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int SW = 32;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]    pol;
  logic [2:0]    stat [NT];
  logic          ne   [NT];
  logic          rdy  [NT];
  logic [SW-1:0] seqv [NT];
  logic [NS-1:0] req;

  logic [NT*3-1:0]  statV;
  logic [NT-1:0]    neV, rdyV;
  logic [NT*SW-1:0] seqV;
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      statV[t*3 +: 3]   = stat[t];
      neV[t]            = ne[t];
      rdyV[t]           = rdy[t];
      seqV[t*SW +: SW]  = seqv[t];
    end
  end

  logic [NS-1:0]   sv;
  logic [NS*2-1:0] st;

  commit_thread_sel #(.NUM_THREADS(NT), .SEQ_W(SW), .NUM_SLOTS(NS)) uut (
    .clk(clk), .rstN(rstN), .policySel(pol), .threadStatus(statV),
    .robNotEmpty(neV), .headReady(rdyV), .headSeq(seqV),
    .slotReq(req), .slotValid(sv), .slotThread(st)
  );

  logic [2:0]    sStat;
  logic          sNe, sRdy;
  logic [SW-1:0] sSeq;
  logic [NS-1:0] sVal;
  logic [NS-1:0] sThr;

  commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW), .NUM_SLOTS(NS)) uutSingle (
    .clk(clk), .rstN(rstN), .policySel(pol), .threadStatus(sStat),
    .robNotEmpty(sNe), .headReady(sRdy), .headSeq(sSeq),
    .slotReq(req), .slotValid(sVal), .slotThread(sThr)
  );

  int checks = 0;
  int fails  = 0;
  int mList [NT];

  function automatic bit okStat(logic [2:0] s);
    return (s == 3'd0) || (s == 3'd1) || (s == 3'd4);
  endfunction

  function automatic bit cand(int t);
    return okStat(stat[t]) && ne[t] && rdy[t];
  endfunction

  task automatic chk(bit cond, string tag, string what, longint act, longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // inputs set at a falling edge; sample a quarter period later, model the edge
  task automatic step(string tag);
    int cur [NT];
    bit adv;
    #(CLK_PERIOD/4);
    cur = mList;
    adv = 1'b0;
    for (int k = 0; k < NS; k++) begin
      bit ev;
      int et;
      bit sev;
      ev = 1'b0;
      et = 0;
      if (req[k]) begin
        if (pol == 2'd0 || pol == 2'd2) begin
          for (int t = 0; t < NT; t++)
            if (cand(t) && (!ev || seqv[t] < seqv[et])) begin ev = 1'b1; et = t; end
        end else if (pol == 2'd1) begin
          int pos;
          pos = 0;
          for (int p = 0; p < NT; p++)
            if (!ev && cand(cur[p])) begin ev = 1'b1; pos = p; end
          if (ev) begin
            int tmp;
            et  = cur[pos];
            tmp = cur[pos];
            for (int i = pos; i < NT - 1; i++) cur[i] = cur[i+1];
            cur[NT-1] = tmp;
            adv = 1'b1;
          end
        end
      end
      chk(sv[k] == ev, tag, $sformatf("slot%0d valid", k), longint'(sv[k]), longint'(ev));
      if (ev) chk(int'(st[k*2 +: 2]) == et, tag, $sformatf("slot%0d thread", k), longint'(st[k*2 +: 2]), longint'(et));
      sev = req[k] && okStat(sStat) && (pol != 2'd3);
      chk(sVal[k] == sev, "R9", $sformatf("single slot%0d valid", k), longint'(sVal[k]), longint'(sev));
      if (sev) chk(sThr[k] == 1'b0, "R9", "single thread", longint'(sThr[k]), 0);
    end
    if (adv) mList = cur;
    @(negedge clk);
  endtask

  task automatic allCand(logic [SW-1:0] s);
    for (int t = 0; t < NT; t++) begin
      stat[t] = 3'd1; ne[t] = 1'b1; rdy[t] = 1'b1; seqv[t] = s;
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd20240611);
    pol = 2'd1;
    req = '0;
    for (int t = 0; t < NT; t++) begin
      stat[t] = 3'd2; ne[t] = 1'b0; rdy[t] = 1'b0; seqv[t] = '0; mList[t] = t;
    end
    sStat = 3'd2; sNe = 1'b0; sRdy = 1'b0; sSeq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R7: reset order puts thread 0 first
    allCand(32'd7); pol = 2'd1; req = 2'b01;
    step("R7");
    // R6: two picks in one cycle, list carried over
    req = 2'b11;
    step("R6");
    step("R6");
    // R4: equal sequences
    pol = 2'd2;
    step("R4");
    seqv[2] = 32'd3; seqv[3] = 32'd3;
    step("R4");
    // R1: status exclusion
    stat[2] = 3'd2;
    step("R1");
    stat[3] = 3'd3; stat[0] = 3'd5;
    step("R1");
    stat[2] = 3'd4;
    step("R1");
    // R2: readiness and occupancy
    allCand(32'd9); rdy[0] = 1'b0; ne[1] = 1'b0;
    step("R2");
    // R3: unsigned compare on full width
    allCand(32'd100); seqv[0] = 32'hFFFF_FFF0; seqv[1] = 32'd5;
    step("R3");
    // R5: greedy gives both slots the same thread
    pol = 2'd0;
    step("R5");
    // R8: policy 3, unrequested slots, no candidates
    pol = 2'd3;
    step("R8");
    pol = 2'd2; req = 2'b00;
    step("R8");
    req = 2'b11; pol = 2'd1;
    for (int t = 0; t < NT; t++) stat[t] = 3'd3;
    step("R8 R10");
    // R10: list unchanged across non-rotating cycles
    allCand(32'd1); pol = 2'd2;
    step("R10");
    pol = 2'd1;
    step("R10");
    // R9: single thread ignores readiness
    sStat = 3'd1; sNe = 1'b0; sRdy = 1'b0;
    step("R9");
    sStat = 3'd2;
    step("R9");

    // seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 10;
      pol = (r == 0) ? 2'd3 : 2'($urandom % 3);
      req = NS'($urandom);
      for (int t = 0; t < NT; t++) begin
        if ($urandom % 4 != 0) begin
          case ($urandom % 3)
            0: stat[t] = 3'd0;
            1: stat[t] = 3'd1;
            default: stat[t] = 3'd4;
          endcase
        end else begin
          stat[t] = 3'($urandom);
        end
        ne[t]   = ($urandom % 5) != 0;
        rdy[t]  = ($urandom % 3) != 0;
        seqv[t] = ($urandom % 2) ? SW'($urandom % 8) : SW'($urandom);
      end
      sStat = 3'($urandom);
      sNe   = 1'($urandom);
      sRdy  = 1'($urandom);
      sSeq  = $urandom;
      step("R3 R5 R6");
    end
    finishRun();
  end

endmodule